// File: doc/BRIEF.md
# Serial Sync-Word Framer and 10-bit Deserializer

The block takes a descrambled bit-serial stream, one bit per clock when `bit_vld` is high. It recovers word boundaries by watching a 30-bit sliding window for the reserved sync pattern. In arrival order the pattern is a run of ten ones followed by a run of twenty zeros. When the window holds that pattern, the block emits a one-clock sync pulse and restarts its divide-by-ten framing counter. The bit that arrives after the last pattern bit becomes bit 0 of a fresh word.

After framing starts, every ten valid bits are packed LSB first into a parallel word. The word is presented together with a one-clock strobe. A sync pattern that lands part-way through a word drops the partial word, and framing moves to the new alignment. Until the first pattern is seen after reset, the block emits no words and the `locked_o` flag stays low.

Top module: `sync_word_framer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `word_o`, `word_stb_o`, `sync_pulse_o` and `locked_o` are all zero.
- R2: `sync_pulse_o` is high for exactly one cycle, namely the cycle after the clock edge that samples the final valid bit of the pattern. The pattern, oldest bit first, is ten 1 bits followed by twenty 0 bits.
- R3: A 30-bit valid-bit sequence that differs from the pattern in any position produces no sync pulse. Examples are nine ones followed by twenty zeros, and ten ones followed by nineteen zeros and then a one.
- R4: After a match, the first valid bit lands in `word_o[0]` and the tenth lands in `word_o[9]`. `word_o` changes only in a cycle where `word_stb_o` is high, and it holds its value otherwise.
- R5: Once locked, `word_stb_o` pulses for one cycle each time ten valid bits have been collected since the last match or the last word.
- R6: A match in the middle of a word discards the partially collected bits. The final pattern bit itself belongs to no word.
- R7: Before the first match after reset, `word_stb_o` stays low and `locked_o` stays low. `locked_o` rises in the same cycle as the first `sync_pulse_o` and then stays high until reset.
- R8: A cycle with `bit_vld` low neither shifts the window nor advances the framing counter, and it causes no pulse and no strobe.
- R9: `word_stb_o` and `sync_pulse_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | `bit_in` carries a valid bit this cycle |
| bit_in | input | 1 | Descrambled serial data bit |
| word_o | output | 10 | Last assembled word, LSB is the earliest bit |
| word_stb_o | output | 1 | One-cycle pulse when `word_o` is refreshed |
| sync_pulse_o | output | 1 | One-cycle pulse after a sync pattern completes |
| locked_o | output | 1 | High from the first sync pattern until reset |

## Verification
A corrupted window register shows up at the ports as a missing sync pulse or a spurious one, within 30 valid bits. A framing counter with the wrong phase shows up as a strobe in the wrong cycle and a rotated word, within ten valid bits of the fault. A wrong accumulator bit appears in the next strobed word. The bench therefore compares all four outputs every clock against an independent queue-based model. Its stimulus covers near-miss patterns, mid-word resynchronisation, back-to-back patterns and long runs with `bit_vld` gaps.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    // Default framing geometry
    localparam int unsigned SFR_WORD_W    = 10;
    localparam int unsigned SFR_ONES_LEN  = 10;
    localparam int unsigned SFR_ZEROS_LEN = 20;

    // Width of a counter that indexes 0..n-1
    function automatic int unsigned sfr_idx_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sfr_window.sv
module sfr_window #(
    parameter int unsigned ONES_LEN  = sfr_pkg::SFR_ONES_LEN,
    parameter int unsigned ZEROS_LEN = sfr_pkg::SFR_ZEROS_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic hit_o,
    output logic sync_pulse_o
);
    localparam int unsigned WIN_W = ONES_LEN + ZEROS_LEN;
    localparam logic [WIN_W-1:0] PATTERN = {{ONES_LEN{1'b1}}, {ZEROS_LEN{1'b0}}};

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             pulse;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [WIN_W-1:0] shifted;
    logic             hit;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.win[WIN_W-2:0], bit_in};
        hit     = bit_vld && (shifted == PATTERN);
        st_d.pulse = hit;
        if (bit_vld) begin
            st_d.win = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o        = hit;
    assign sync_pulse_o = st_q.pulse;

    // R8
    sync_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |-> $past(bit_vld));

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |=> !sync_pulse_o);
endmodule

// File: rtl/sfr_packer.sv
module sfr_packer #(
    parameter int unsigned WORD_W = sfr_pkg::SFR_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              hit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_stb_o,
    output logic              locked_o
);
    localparam int unsigned CNT_W = sfr_pkg::sfr_idx_w(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              stb;
        logic              locked;
    } pack_state_t;

    pack_state_t       st_d, st_q;
    logic [WORD_W-1:0] acc_next;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        acc_next = st_q.acc;
        acc_next[st_q.cnt] = bit_in;
        if (bit_vld) begin
            if (hit_i) begin
                st_d.acc    = '0;
                st_d.cnt    = '0;
                st_d.locked = 1'b1;
            end else if (st_q.cnt == LAST) begin
                st_d.acc = '0;
                st_d.cnt = '0;
                if (st_q.locked) begin
                    st_d.word = acc_next;
                    st_d.stb  = 1'b1;
                end
            end else begin
                st_d.acc = acc_next;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o     = st_q.word;
    assign word_stb_o = st_q.stb;
    assign locked_o   = st_q.locked;

    // R7
    stb_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> locked_o);

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(locked_o));

    // R9
    no_stb_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> !$past(hit_i));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb_o |-> $stable(word_o));
endmodule

// File: rtl/sync_word_framer.sv
module sync_word_framer #(
    parameter int unsigned WORD_W    = sfr_pkg::SFR_WORD_W,
    parameter int unsigned ONES_LEN  = sfr_pkg::SFR_ONES_LEN,
    parameter int unsigned ZEROS_LEN = sfr_pkg::SFR_ZEROS_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_o,
    output logic              word_stb_o,
    output logic              sync_pulse_o,
    output logic              locked_o
);
    logic hit;

    sfr_window #(
        .ONES_LEN (ONES_LEN),
        .ZEROS_LEN(ZEROS_LEN)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .hit_o       (hit),
        .sync_pulse_o(sync_pulse_o)
    );

    sfr_packer #(
        .WORD_W(WORD_W)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .hit_i     (hit),
        .word_o    (word_o),
        .word_stb_o(word_stb_o),
        .locked_o  (locked_o)
    );

    // R9
    no_stb_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_stb_o && sync_pulse_o));

    // R7
    sync_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |-> locked_o);
endmodule

// File: tb/tb_sync_word_framer.sv
module tb_sync_word_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [9:0] word_o;
    logic       word_stb_o, sync_pulse_o, locked_o;

    always #5 clk = ~clk;

    sync_word_framer dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .word_o(word_o), .word_stb_o(word_stb_o),
        .sync_pulse_o(sync_pulse_o), .locked_o(locked_o)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Behavioural reference state
    bit         hist[$];
    int         m_cnt = 0;
    logic [9:0] m_acc = '0;
    logic [9:0] e_word = '0;
    logic       e_stb = 0, e_sync = 0, e_locked = 0;

    function automatic bit is_pattern();
        if (hist.size() != 30) return 0;
        for (int i = 0; i < 30; i++) begin
            if (hist[i] != (i < 10)) return 0;
        end
        return 1;
    endfunction

    task automatic model_step(input bit v, input bit b);
        e_stb  = 0;
        e_sync = 0;
        if (!v) return;               // R8: no effect
        hist.push_back(b);
        if (hist.size() > 30) void'(hist.pop_front());
        if (is_pattern()) begin       // R2 / R6
            e_sync   = 1;
            e_locked = 1;
            m_cnt    = 0;
            m_acc    = '0;
        end else begin
            m_acc[m_cnt] = b;         // R4 LSB first
            m_cnt++;
            if (m_cnt == 10) begin
                if (e_locked) begin   // R7 gating
                    e_word = m_acc;
                    e_stb  = 1;
                end
                m_cnt = 0;
                m_acc = '0;
            end
        end
    endtask

    task automatic compare();
        vectors++;
        if (sync_pulse_o !== e_sync) begin
            fails++;
            $display("FAIL R2/R3 sync_pulse_o=%b expected %b at %0t", sync_pulse_o, e_sync, $time);
        end
        if (word_stb_o !== e_stb) begin
            fails++;
            $display("FAIL R5/R6/R7 word_stb_o=%b expected %b at %0t", word_stb_o, e_stb, $time);
        end
        if (word_o !== e_word) begin
            fails++;
            $display("FAIL R4 word_o=%h expected %h at %0t", word_o, e_word, $time);
        end
        if (locked_o !== e_locked) begin
            fails++;
            $display("FAIL R7 locked_o=%b expected %b at %0t", locked_o, e_locked, $time);
        end
    endtask

    task automatic send(input bit v, input bit b);
        bit_vld = v;
        bit_in  = b;
        model_step(v, b);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic send_rand(input int n, input int vld_pct);
        for (int i = 0; i < n; i++) begin
            send(($urandom % 100) < vld_pct, $urandom % 2);
        end
    endtask

    // Pattern with optional idle gaps between bits
    task automatic send_pattern(input bit gaps);
        for (int i = 0; i < 30; i++) begin
            if (gaps && (i % 7 == 3)) send(0, 1);
            send(1, i < 10);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, actual hung expected finished");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        compare();

        // R7: unlocked traffic yields no words
        send_rand(63, 100);
        // R3: near misses
        for (int i = 0; i < 9; i++) send(1, 1);
        for (int i = 0; i < 20; i++) send(1, 0);
        send(1, 1);
        for (int i = 0; i < 10; i++) send(1, 1);
        for (int i = 0; i < 19; i++) send(1, 0);
        send(1, 1);
        send_rand(5, 100);

        // R2/R7: first lock
        send_pattern(0);
        // R4/R5: aligned words
        send_rand(57, 100);
        // R6: mid-word resync
        send_pattern(0);
        send_rand(43, 100);
        // R8: gaps, including inside the pattern
        send_rand(200, 60);
        send_pattern(1);
        send_rand(80, 70);
        // Back-to-back patterns
        send_pattern(0);
        send_pattern(0);
        send_rand(33, 100);
        // Long random soak with occasional patterns
        for (int k = 0; k < 20; k++) begin
            send_rand(37 + k, 85);
            send_pattern(k % 2);
        end
        send_rand(50, 100);

        // R1: reset again clears everything
        rst_n = 0;
        hist.delete();
        m_cnt = 0; m_acc = '0; e_word = '0; e_stb = 0; e_sync = 0; e_locked = 0;
        bit_vld = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1;
        send_rand(40, 100);
        summary();
    end
endmodule